// File: doc/BRIEF.md
# Polar Decoder Bit-Flip Scheduler

This block sequences the retry attempts of a successive-cancellation decoder that uses bit flipping on a short polar code. When a frame starts, it captures three inputs. The first is the information-bit pattern of the code. The second is one error score per information bit, which some external predictor supplies. The third is a reliability rank for each codeword position. The scheduler then asks the decoder for a series of decode passes. Each request carries a flip mask that names zero, one or two codeword positions to invert. After each pass the decoder returns a done strobe and a CRC verdict.

The first request always uses an empty mask. If that pass fails, the scheduler ranks the information bits by score and keeps the strongest T1 of them as candidates. It maps each candidate to its codeword position and tries them one at a time. If every single flip fails, it ranks the same candidates again, this time from least to most reliable, and tries pairs of them together. It stops after at most T2 pairs. The first passing CRC ends the frame with success. If no attempt passes, the frame ends with failure. A counter reports how many decode requests the frame used.

Top module: `bfs_scheduler`

## Requirements
- R1: The first decode request after a start of frame carries an all-zero flip mask. If that pass returns a passing CRC, the frame ends with success and an attempt count of 1.
- R2: A flip mask only ever sets bits at information positions, which are the set bits of the captured pattern (bit p of the pattern corresponds to codeword position p). Information index j maps to the position of the (j+1)-th set bit, counting from bit 0 upward.
- R3: After a failed plain pass, the scheduler issues exactly T1 single-bit requests. It visits the T1 highest-scoring information indices in descending score order, and on equal scores the lower information index goes first. Each request sets only the mapped position of its candidate.
- R4: The first request whose pass returns a passing CRC ends the frame with success, and no further request is issued.
- R5: After all single flips fail, the candidates are reordered by ascending reliability rank of their positions (a lower rank value means less reliable). On equal ranks the earlier candidate in score order goes first. The first pair request inverts the two least reliable candidates.
- R6: Pair requests follow the order (0,1), (0,2), (1,2), (0,3), (1,3), (2,3), and so on, over indices into the reliability order.
- R7: The number of pair requests is capped at T2, and also at the total number of distinct pairs. When every allowed request has failed, the frame ends with failure and an attempt count of 1 + T1 + number of pairs.
- R8: Each request is a one-cycle pulse on dec_start_o. The flip mask holds stable until the decoder's done strobe arrives. A done strobe that arrives while no request is outstanding is ignored.
- R9: A start of frame restarts the scheduler even in the middle of a frame. It clears the outcome flags and resets the attempt count, so the next request is counted as attempt 1.
- R10: busy_o stays high from the cycle after a start of frame until the outcome is known. success_o and failure_o are never both high, never high while busy, and hold their value until the next start of frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Start of frame; captures the three input vectors |
| info_mask_i | input | N | Information pattern, 1 = information position |
| score_i | input | K*SW | Error score per information index, index j at bits j*SW |
| rel_i | input | N*RW | Reliability rank per position, position p at bits p*RW |
| dec_start_o | output | 1 | One-cycle decode request |
| flip_mask_o | output | N | Positions to invert in the requested pass |
| dec_done_i | input | 1 | Decoder finished the outstanding pass |
| crc_ok_i | input | 1 | CRC verdict, valid with dec_done_i |
| busy_o | output | 1 | Frame in progress |
| success_o | output | 1 | Frame decoded |
| failure_o | output | 1 | All attempts exhausted |
| attempts_o | output | AW | Decode requests issued in this frame |

## Verification
The bench uses N=16, K=8, T1=4 and T2=5. With T2=5 there are fewer pair requests allowed than the six distinct pairs of four candidates, so the T2 cap is the limit that ends a failing frame. These values also reach pairs that include index 3 of the reliability order. Score and rank values are drawn from a narrow range, so ties occur often and both tie rules get tested. The directed frames cover a success on the plain pass, on the last single flip and on the first pair. They also cover a complete failure, a stray done strobe during ranking and after the frame ends, and a restart in the middle of a frame.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_RANK1 = 2'd2,
        ST_RANK2 = 2'd3
    } bfs_state_e;

    typedef enum logic [1:0] {
        PH_PLAIN  = 2'd0,
        PH_SINGLE = 2'd1,
        PH_PAIR   = 2'd2
    } bfs_phase_e;

endpackage

// File: rtl/bfs_posmap.sv
// Maps information index j to the codeword position of the (j+1)-th set
// bit of the pattern, counting from position 0 upward.
module bfs_posmap #(
    parameter int N  = 16,
    parameter int K  = 8,
    localparam int PW = $clog2(N)
) (
    input  logic [N-1:0]    info_i,
    output logic [K*PW-1:0] pos_o
);

    always_comb begin
        int cnt;
        cnt   = 0;
        pos_o = '0;
        for (int p = 0; p < N; p++) begin
            if (info_i[p] && cnt < K) begin
                pos_o[cnt*PW +: PW] = PW'(p);
                cnt = cnt + 1;
            end
        end
    end

endmodule

// File: rtl/bfs_rank.sv
// Iterative selection: each active cycle picks the best unused key
// (largest if DESC, else smallest; lowest index wins ties). Takes T cycles.
module bfs_rank #(
    parameter int M    = 8,
    parameter int T    = 4,
    parameter int W    = 8,
    parameter bit DESC = 1'b1,
    localparam int IW  = (M > 1) ? $clog2(M) : 1,
    localparam int TW  = (T > 1) ? $clog2(T) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_i,
    input  logic [M*W-1:0]  keys_i,
    output logic [T*IW-1:0] order_o,
    output logic            ready_o
);

    typedef struct packed {
        logic [M-1:0]    used;
        logic [TW-1:0]   cnt;
        logic            active;
        logic            ready;
        logic [T*IW-1:0] order;
    } rank_t;

    rank_t q, d;
    logic [IW-1:0] best;

    always_comb begin
        logic          found;
        logic [W-1:0]  bkey;
        logic [W-1:0]  key;
        found = 1'b0;
        bkey  = '0;
        best  = '0;
        for (int j = 0; j < M; j++) begin
            key = keys_i[j*W +: W];
            if (!q.used[j]) begin
                if (!found || (DESC ? (key > bkey) : (key < bkey))) begin
                    found = 1'b1;
                    bkey  = key;
                    best  = IW'(j);
                end
            end
        end
    end

    always_comb begin
        d = q;
        if (go_i) begin
            d.used   = '0;
            d.cnt    = '0;
            d.active = 1'b1;
            d.ready  = 1'b0;
        end else if (q.active) begin
            d.order[int'(q.cnt)*IW +: IW] = best;
            d.used[best] = 1'b1;
            if (q.cnt == TW'(T-1)) begin
                d.active = 1'b0;
                d.ready  = 1'b1;
            end else begin
                d.cnt = q.cnt + TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign order_o = q.order;
    assign ready_o = q.ready;

    // R3: one index consumed per active cycle, never reused
    assert_used_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.active |-> ($countones(q.used) == int'(q.cnt)));

    assert_ready_after_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ready) |-> ($countones(q.used) == T));

endmodule

// File: rtl/bfs_scheduler.sv
module bfs_scheduler
    import bfs_pkg::*;
#(
    parameter int N  = 16,
    parameter int K  = 8,
    parameter int T1 = 4,
    parameter int T2 = 5,
    parameter int SW = 8,
    parameter int RW = 4,
    localparam int PW        = $clog2(N),
    localparam int KIW       = $clog2(K),
    localparam int CW        = $clog2(T1),
    localparam int NPAIR_ALL = T1 * (T1 - 1) / 2,
    localparam int NPAIR     = (T2 < NPAIR_ALL) ? T2 : NPAIR_ALL,
    localparam int PCW       = (NPAIR > 1) ? $clog2(NPAIR) : 1,
    localparam int MAXATT    = 1 + T1 + NPAIR,
    localparam int AW        = $clog2(MAXATT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sof_i,
    input  logic [N-1:0]    info_mask_i,
    input  logic [K*SW-1:0] score_i,
    input  logic [N*RW-1:0] rel_i,
    output logic            dec_start_o,
    output logic [N-1:0]    flip_mask_o,
    input  logic            dec_done_i,
    input  logic            crc_ok_i,
    output logic            busy_o,
    output logic            success_o,
    output logic            failure_o,
    output logic [AW-1:0]   attempts_o
);

    typedef struct packed {
        bfs_state_e      state;
        bfs_phase_e      phase;
        logic [N-1:0]    info;
        logic [K*SW-1:0] score;
        logic [N*RW-1:0] rel;
        logic [CW-1:0]   idx;
        logic [CW-1:0]   pa;
        logic [CW-1:0]   pb;
        logic [PCW-1:0]  pcnt;
        logic [AW-1:0]   att;
        logic [N-1:0]    mask;
        logic            start;
        logic            go1;
        logic            go2;
        logic            succ;
        logic            fail;
        logic            busy;
    } sched_t;

    sched_t q, d;

    logic [K*PW-1:0]  map_pos;
    logic [T1*KIW-1:0] r1_order;
    logic [T1*CW-1:0] r2_order;
    logic             r1_ready, r2_ready;
    logic [PW-1:0]    cand_pos [T1];
    logic [PW-1:0]    rpos     [T1];
    logic [T1*RW-1:0] cand_rel;

    bfs_posmap #(.N(N), .K(K)) u_posmap (
        .info_i (q.info),
        .pos_o  (map_pos)
    );

    bfs_rank #(.M(K), .T(T1), .W(SW), .DESC(1'b1)) u_score_rank (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (q.go1),
        .keys_i  (q.score),
        .order_o (r1_order),
        .ready_o (r1_ready)
    );

    always_comb begin
        for (int i = 0; i < T1; i++) begin
            cand_pos[i] = map_pos[int'(r1_order[i*KIW +: KIW])*PW +: PW];
            cand_rel[i*RW +: RW] = q.rel[int'(cand_pos[i])*RW +: RW];
        end
        for (int k = 0; k < T1; k++) begin
            rpos[k] = cand_pos[r2_order[k*CW +: CW]];
        end
    end

    bfs_rank #(.M(T1), .T(T1), .W(RW), .DESC(1'b0)) u_rel_rank (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (q.go2),
        .keys_i  (cand_rel),
        .order_o (r2_order),
        .ready_o (r2_ready)
    );

    function automatic logic [N-1:0] bit_at(input logic [PW-1:0] p);
        logic [N-1:0] m;
        m = '0;
        m[p] = 1'b1;
        return m;
    endfunction

    always_comb begin
        logic [CW-1:0] nidx, na, nb;
        d       = q;
        d.start = 1'b0;
        d.go1   = 1'b0;
        d.go2   = 1'b0;
        nidx    = q.idx + CW'(1);
        if (int'(q.pa) + 1 < int'(q.pb)) begin
            na = q.pa + CW'(1);
            nb = q.pb;
        end else begin
            na = '0;
            nb = q.pb + CW'(1);
        end

        if (sof_i) begin
            d.info  = info_mask_i;
            d.score = score_i;
            d.rel   = rel_i;
            d.att   = AW'(1);
            d.mask  = '0;
            d.start = 1'b1;
            d.state = ST_WAIT;
            d.phase = PH_PLAIN;
            d.succ  = 1'b0;
            d.fail  = 1'b0;
            d.busy  = 1'b1;
        end else begin
            case (q.state)
                ST_WAIT: begin
                    if (dec_done_i && !q.start) begin
                        if (crc_ok_i) begin
                            d.succ  = 1'b1;
                            d.busy  = 1'b0;
                            d.state = ST_IDLE;
                        end else begin
                            case (q.phase)
                                PH_PLAIN: begin
                                    d.go1   = 1'b1;
                                    d.state = ST_RANK1;
                                end
                                PH_SINGLE: begin
                                    if (q.idx == CW'(T1 - 1)) begin
                                        d.go2   = 1'b1;
                                        d.state = ST_RANK2;
                                    end else begin
                                        d.idx   = nidx;
                                        d.mask  = bit_at(cand_pos[nidx]);
                                        d.start = 1'b1;
                                        d.att   = q.att + AW'(1);
                                    end
                                end
                                default: begin
                                    if (q.pcnt == PCW'(NPAIR - 1)) begin
                                        d.fail  = 1'b1;
                                        d.busy  = 1'b0;
                                        d.state = ST_IDLE;
                                    end else begin
                                        d.pa    = na;
                                        d.pb    = nb;
                                        d.pcnt  = q.pcnt + PCW'(1);
                                        d.mask  = bit_at(rpos[na]) | bit_at(rpos[nb]);
                                        d.start = 1'b1;
                                        d.att   = q.att + AW'(1);
                                    end
                                end
                            endcase
                        end
                    end
                end
                ST_RANK1: begin
                    if (r1_ready && !q.go1) begin
                        d.phase = PH_SINGLE;
                        d.idx   = '0;
                        d.mask  = bit_at(cand_pos[0]);
                        d.start = 1'b1;
                        d.att   = q.att + AW'(1);
                        d.state = ST_WAIT;
                    end
                end
                ST_RANK2: begin
                    if (r2_ready && !q.go2) begin
                        d.phase = PH_PAIR;
                        d.pa    = '0;
                        d.pb    = CW'(1);
                        d.pcnt  = '0;
                        d.mask  = bit_at(rpos[0]) | bit_at(rpos[1]);
                        d.start = 1'b1;
                        d.att   = q.att + AW'(1);
                        d.state = ST_WAIT;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dec_start_o = q.start;
    assign flip_mask_o = q.mask;
    assign busy_o      = q.busy;
    assign success_o   = q.succ;
    assign failure_o   = q.fail;
    assign attempts_o  = q.att;

    assert_plain_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_start_o && attempts_o == AW'(1)) |-> (flip_mask_o == '0));

    assert_no_frozen_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_start_o |-> ((flip_mask_o & ~q.info) == '0));

    assert_flip_weight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_start_o |-> ($countones(flip_mask_o) <= 2));

    assert_stop_on_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        success_o |-> !dec_start_o);

    assert_attempt_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(attempts_o) <= MAXATT);

    assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_start_o |=> !dec_start_o);

    assert_mask_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WAIT && !dec_done_i && !sof_i) |=> $stable(flip_mask_o));

    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> (dec_start_o && attempts_o == AW'(1) && busy_o && !success_o && !failure_o));

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(success_o && failure_o) && !(busy_o && (success_o || failure_o)));

    assert_busy_ends_with_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (success_o || failure_o));

endmodule

// File: tb/bfs_scheduler_bench.sv
module bfs_scheduler_bench;

    localparam int N  = 16;
    localparam int K  = 8;
    localparam int T1 = 4;
    localparam int T2 = 5;
    localparam int SW = 8;
    localparam int RW = 4;
    localparam int NP = 5;
    localparam int AW = $clog2(1 + T1 + NP + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sof = 1'b0;
    logic [N-1:0]    info = '0;
    logic [K*SW-1:0] score = '0;
    logic [N*RW-1:0] rel = '0;
    logic            dec_start;
    logic [N-1:0]    flip_mask;
    logic            dec_done = 1'b0;
    logic            crc_ok = 1'b0;
    logic            busy, success, failure;
    logic [AW-1:0]   attempts;

    int checks = 0;
    int fails  = 0;

    logic [N-1:0] exp_mask [16];
    int           exp_n;

    always #5 clk = ~clk;

    bfs_scheduler #(.N(N), .K(K), .T1(T1), .T2(T2), .SW(SW), .RW(RW)) u_bfs_scheduler (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_i       (sof),
        .info_mask_i (info),
        .score_i     (score),
        .rel_i       (rel),
        .dec_start_o (dec_start),
        .flip_mask_o (flip_mask),
        .dec_done_i  (dec_done),
        .crc_ok_i    (crc_ok),
        .busy_o      (busy),
        .success_o   (success),
        .failure_o   (failure),
        .attempts_o  (attempts)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Reference request list from the requirements (R2, R3, R5, R6, R7)
    function automatic void build_expected();
        int  pos [K];
        int  cand [T1];
        int  rp [T1];
        bit  usedk [K];
        bit  usedt [T1];
        int  c, best, n;
        c = 0;
        for (int p = 0; p < N; p++)
            if (info[p] && c < K) begin pos[c] = p; c++; end
        for (int j = 0; j < K; j++) usedk[j] = 0;
        for (int i = 0; i < T1; i++) begin
            best = -1;
            for (int j = 0; j < K; j++)
                if (!usedk[j] && (best < 0 || score[j*SW +: SW] > score[best*SW +: SW])) best = j;
            usedk[best] = 1;
            cand[i] = pos[best];
        end
        for (int i = 0; i < T1; i++) usedt[i] = 0;
        for (int k = 0; k < T1; k++) begin
            best = -1;
            for (int i = 0; i < T1; i++)
                if (!usedt[i] && (best < 0 || rel[cand[i]*RW +: RW] < rel[cand[best]*RW +: RW])) best = i;
            usedt[best] = 1;
            rp[k] = cand[best];
        end
        exp_mask[0] = '0;
        for (int i = 0; i < T1; i++) exp_mask[1+i] = N'(1) << cand[i];
        n = 1 + T1;
        for (int b = 1; b < T1; b++)
            for (int a = 0; a < b; a++)
                if (n < 1 + T1 + NP) begin
                    exp_mask[n] = (N'(1) << rp[a]) | (N'(1) << rp[b]);
                    n++;
                end
        exp_n = n;
    endfunction

    // target: index of the request whose CRC passes, or -1 for none
    task automatic run_frame(input int target, input bit spur);
        int n, guard, want_n;
        bit st0, fl0;
        build_expected();
        @(negedge clk); sof = 1'b1;
        @(negedge clk); sof = 1'b0;
        n = 0;
        guard = 0;
        forever begin
            if (dec_start) begin
                if (n < exp_n)
                    check(flip_mask == exp_mask[n], (n == 0) ? "R1 plain mask" :
                          (n <= T1) ? "R3 single mask" : "R5/R6 pair mask",
                          32'(flip_mask), 32'(exp_mask[n]));
                else
                    check(1'b0, "R7 extra request", 32'(n), 32'(exp_n));
                check(int'(attempts) == n + 1, "R9 attempt count", 32'(attempts), 32'(n + 1));
                n++;
                @(negedge clk);
                @(negedge clk);
                dec_done = 1'b1;
                crc_ok   = (n - 1 == target);
                @(negedge clk);
                dec_done = 1'b0;
                crc_ok   = 1'b0;
                if (spur && n == 1 && target != 0) begin
                    dec_done = 1'b1;
                    crc_ok   = 1'b1;
                    @(negedge clk);
                    dec_done = 1'b0;
                    crc_ok   = 1'b0;
                end
            end else if (!busy) begin
                break;
            end else begin
                @(negedge clk);
            end
            guard++;
            if (guard > 2000) begin
                check(1'b0, "R8 frame stalled", 32'(n), 32'(exp_n));
                break;
            end
        end
        want_n = (target >= 0) ? target + 1 : exp_n;
        check(n == want_n, (target >= 0) ? "R4 request count" : "R7 request count", 32'(n), 32'(want_n));
        check(int'(attempts) == want_n, "R7 attempts", 32'(attempts), 32'(want_n));
        check(success == (target >= 0), "R4 success", 32'(success), 32'(target >= 0));
        check(failure == (target < 0), "R7 failure", 32'(failure), 32'(target < 0));
        if (spur) begin
            st0 = success; fl0 = failure;
            dec_done = 1'b1; crc_ok = ~success;
            @(negedge clk);
            dec_done = 1'b0; crc_ok = 1'b0;
            for (int i = 0; i < 4; i++) begin
                check(!dec_start, "R8 stray done starts nothing", 32'(dec_start), 32'd0);
                @(negedge clk);
            end
            check(success == st0 && failure == fl0 && !busy, "R10 flags held",
                  {30'd0, success, failure}, {30'd0, st0, fl0});
        end
    endtask

    task automatic randomize_inputs();
        int perm [N];
        int j, t;
        for (int i = 0; i < N; i++) perm[i] = i;
        for (int i = N - 1; i > 0; i--) begin
            j = $urandom_range(0, i);
            t = perm[i]; perm[i] = perm[j]; perm[j] = t;
        end
        info = '0;
        for (int i = 0; i < K; i++) info[perm[i]] = 1'b1;
        for (int i = 0; i < K; i++) score[i*SW +: SW] = SW'($urandom_range(0, 15));
        for (int p = 0; p < N; p++) rel[p*RW +: RW] = RW'($urandom_range(0, 15));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(!busy && !success && !failure && !dec_start && attempts == '0,
              "R10 reset state", {27'd0, busy, success, failure, dec_start, attempts != '0}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: pattern with positions 7,9..15, equal scores and ranks (R2)
        info  = 16'hFE80;
        score = '0;
        rel   = '0;
        run_frame(0, 1'b0);          // R1
        run_frame(T1, 1'b0);         // R3 last single
        run_frame(T1 + 1, 1'b0);     // R5 first pair
        run_frame(-1, 1'b1);         // R7 exhaust, R8 stray done

        // Directed: distinct scores and ranks
        for (int i = 0; i < K; i++) score[i*SW +: SW] = SW'(i * 3);
        for (int p = 0; p < N; p++) rel[p*RW +: RW] = RW'(N - 1 - p);
        run_frame(T1 + NP, 1'b1);    // R6 last pair

        // Restart in the middle of a frame (R9)
        @(negedge clk); sof = 1'b1;
        @(negedge clk); sof = 1'b0;
        @(negedge clk);
        randomize_inputs();
        run_frame(2, 1'b0);

        for (int f = 0; f < 40; f++) begin
            randomize_inputs();
            run_frame($urandom_range(0, 1 + T1 + NP) - 1, f[0]);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule